// File: doc/BRIEF.md
# Relocatable Reset and Interrupt Vector Generator

This block tells the processor core where to fetch after a reset and on interrupt entry. It watches a reset request pulse and eighteen interrupt request lines. It picks the event to take, forms the program-memory word address of its vector, and presents that address with a one-cycle valid strobe. It also reports the table offset of the event taken and gives the chosen source a one-cycle acknowledge.

Two controls move the targets, and they act independently of each other. A boot fuse input, active low (0 = programmed), moves the reset target from address 0 to the boot-section start address. A vector-relocate bit moves the interrupt vector base from 0 to the same start address. All four combinations are legal. For example, the reset target can stay at 0 while the interrupt vectors sit in the boot section. The block also holds the global interrupt enable. The core sets and clears it through two pulse inputs. Taking an interrupt clears it.

Top module: `irqv_top`

## Requirements
- R1: While `rst_n` is low and after its release, `fetch_vld` is 0, `irq_ack` is all zeros and `irq_en` is 0 until an input changes them.
- R2: A cycle with `reset_req` high gives, on the next cycle, `fetch_vld` = 1, `fetch_idx` = 0 and `fetch_addr` = `boot_base` when `boot_fuse_n` = 0, or 0 when `boot_fuse_n` = 1.
- R3: `reset_req` is taken whether or not `irq_en` is set, and it wins over any pending request. The cycle it is taken gives no acknowledge and clears `irq_en`.
- R4: An interrupt vector address is the table offset plus `boot_base` when `vec_sel` = 1, and the offset alone when `vec_sel` = 0. Both inputs are sampled on the edge where the interrupt is taken. `boot_fuse_n` has no effect on interrupt vectors, and `vec_sel` has no effect on the reset target.
- R5: An interrupt is taken only in a cycle where `irq_en` is 1 and a request is pending. Taking it gives `irq_en` = 0 on the next cycle.
- R6: Request bit k (k = 0 to 17) has table offset k+1. When several bits are set, the lowest offset wins, and `fetch_idx` shows that offset. The offsets, in order, are: external line 0, external line 1, timer 2 compare, timer 2 overflow, timer 1 capture, timer 1 compare A, timer 1 compare B, timer 1 overflow, timer 0 overflow, SPI done, serial receive done, serial transmit buffer empty, serial transmit done, ADC done, non-volatile write done, comparator, two-wire bus, self-program done.
- R7: Taking an interrupt drives `irq_ack` with only bit k set, in the same cycle as `fetch_vld`, for one cycle.
- R8: In a cycle with nothing taken, `ie_clr` = 1 makes `irq_en` 0 on the next cycle. Otherwise `ie_set` = 1 makes it 1. When an event is taken in the same cycle, the clear caused by the take wins over `ie_set`.
- R9: In a cycle with no reset request and no interrupt taken, `fetch_vld` is 0 on the next cycle, and `fetch_addr` and `fetch_idx` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boot_fuse_n | input | 1 | Boot reset fuse, 0 = programmed (reset goes to the boot section) |
| vec_sel | input | 1 | 1 = interrupt vectors placed at the boot-section start |
| boot_base | input | AW | Word address of the boot-section start |
| reset_req | input | 1 | Reset request pulse |
| ie_set | input | 1 | Set the global interrupt enable |
| ie_clr | input | 1 | Clear the global interrupt enable |
| irq_req | input | NSRC | Interrupt request lines, bit k has offset k+1 |
| fetch_vld | output | 1 | One-cycle strobe: a fetch address is presented |
| fetch_addr | output | AW | Vector word address |
| fetch_idx | output | IW | Table offset of the event taken (0 = reset) |
| irq_ack | output | NSRC | One-hot acknowledge of the source taken |
| irq_en | output | 1 | Global interrupt enable state |

## Verification
The hardest situations to reach from the ports are two collisions. In the first, a reset request lands in the same cycle as a pending request that is enabled. In the second, a take lands in the same cycle as `ie_set` or `ie_clr`. These only appear when the enable is set exactly one cycle before the collision. Directed steps set the enable, hold requests pending, and then assert the competing input on the edge where the take would happen. All four fuse and relocate combinations are walked through explicitly. A long pseudo-random phase then mixes sparse requests, frequent enable pulses and rare reset requests, and checks every cycle against a behavioural model.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Decision taken in a cycle
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_RESET = 2'd1,
    ACT_IRQ   = 2'd2
  } act_e;

  // Table offsets, listed in priority order (lower value wins)
  typedef enum logic [4:0] {
    SRC_RESET        = 5'd0,
    SRC_EXT0         = 5'd1,
    SRC_EXT1         = 5'd2,
    SRC_T2_CMP       = 5'd3,
    SRC_T2_OVF       = 5'd4,
    SRC_T1_CAP       = 5'd5,
    SRC_T1_CMPA      = 5'd6,
    SRC_T1_CMPB      = 5'd7,
    SRC_T1_OVF       = 5'd8,
    SRC_T0_OVF       = 5'd9,
    SRC_SPI_DONE     = 5'd10,
    SRC_UART_RX      = 5'd11,
    SRC_UART_TXE     = 5'd12,
    SRC_UART_TX      = 5'd13,
    SRC_ADC_DONE     = 5'd14,
    SRC_NVM_RDY      = 5'd15,
    SRC_ACMP         = 5'd16,
    SRC_TWI          = 5'd17,
    SRC_SELFPROG_RDY = 5'd18
  } src_e;

endpackage

// File: rtl/irqv_prio.sv
// Fixed-priority selector: the lowest request index wins.
module irqv_prio #(
  parameter int N  = 18,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  win_oh,
  output logic [IW-1:0] win_off,
  output logic          any
);

  logic [N:0]    blocked;
  logic [IW-1:0] off_term [N];

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign blocked[i+1] = blocked[i] | req[i];
    assign win_oh[i]    = req[i] & ~blocked[i];
    assign off_term[i]  = win_oh[i] ? IW'(i + 1) : '0;
  end

  assign any = blocked[N];

  always_comb begin
    win_off = '0;
    for (int i = 0; i < N; i++) begin
      win_off = win_off | off_term[i];
    end
  end

endmodule

// File: rtl/irqv_addr.sv
// Forms a vector address from an optional base plus a table offset.
module irqv_addr #(
  parameter int AW = 16,
  parameter int IW = 5
) (
  input  logic          use_base,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] offset,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] base_sel;

  assign base_sel = use_base ? base : '0;
  assign addr     = base_sel + AW'(offset);

endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter  int AW   = 16,
  parameter  int NSRC = 18,
  localparam int IW   = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boot_fuse_n,
  input  logic            vec_sel,
  input  logic [AW-1:0]   boot_base,
  input  logic            reset_req,
  input  logic            ie_set,
  input  logic            ie_clr,
  input  logic [NSRC-1:0] irq_req,
  output logic            fetch_vld,
  output logic [AW-1:0]   fetch_addr,
  output logic [IW-1:0]   fetch_idx,
  output logic [NSRC-1:0] irq_ack,
  output logic            irq_en
);

  // Priority selection
  logic [NSRC-1:0] win_oh;
  logic [IW-1:0]   win_off;
  logic            req_any;

  irqv_prio #(.N(NSRC), .IW(IW)) u_prio (
    .req     (irq_req),
    .win_oh  (win_oh),
    .win_off (win_off),
    .any     (req_any)
  );

  // Address formation: reset target and interrupt base relocate separately
  logic [AW-1:0] rst_addr;
  logic [AW-1:0] irq_addr;

  irqv_addr #(.AW(AW), .IW(IW)) u_rst_addr (
    .use_base (~boot_fuse_n),
    .base     (boot_base),
    .offset   ({IW{1'b0}}),
    .addr     (rst_addr)
  );

  irqv_addr #(.AW(AW), .IW(IW)) u_irq_addr (
    .use_base (vec_sel),
    .base     (boot_base),
    .offset   (win_off),
    .addr     (irq_addr)
  );

  // State
  logic            en_q,   en_d;
  logic            vld_q,  vld_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [IW-1:0]   idx_q,  idx_d;
  logic [NSRC-1:0] ack_q,  ack_d;
  logic            ld_en;
  act_e            act;

  // Next state
  always_comb begin
    if (reset_req) begin
      act = ACT_RESET;
    end else if (en_q && req_any) begin
      act = ACT_IRQ;
    end else begin
      act = ACT_NONE;
    end
  end

  always_comb begin
    en_d   = en_q;
    vld_d  = 1'b0;
    ld_en  = 1'b0;
    addr_d = addr_q;
    idx_d  = idx_q;
    ack_d  = '0;
    unique case (act)
      ACT_RESET: begin
        en_d   = 1'b0;
        vld_d  = 1'b1;
        ld_en  = 1'b1;
        addr_d = rst_addr;
        idx_d  = '0;
      end
      ACT_IRQ: begin
        en_d   = 1'b0;
        vld_d  = 1'b1;
        ld_en  = 1'b1;
        addr_d = irq_addr;
        idx_d  = win_off;
        ack_d  = win_oh;
      end
      default: begin
        if (ie_clr) begin
          en_d = 1'b0;
        end else if (ie_set) begin
          en_d = 1'b1;
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vld_q <= 1'b0;
      ack_q <= '0;
    end else begin
      en_q  <= en_d;
      vld_q <= vld_d;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (ld_en) begin
      addr_q <= addr_d;
      idx_q  <= idx_d;
    end
  end

  assign fetch_vld  = vld_q;
  assign fetch_addr = addr_q;
  assign fetch_idx  = idx_q;
  assign irq_ack    = ack_q;
  assign irq_en     = en_q;

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter  int AW   = 16,
  parameter  int NSRC = 18,
  localparam int IW   = $clog2(NSRC + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            boot_fuse_n,
  input logic            vec_sel,
  input logic [AW-1:0]   boot_base,
  input logic            reset_req,
  input logic            ie_set,
  input logic            ie_clr,
  input logic [NSRC-1:0] irq_req,
  input logic            fetch_vld,
  input logic [AW-1:0]   fetch_addr,
  input logic [IW-1:0]   fetch_idx,
  input logic [NSRC-1:0] irq_ack,
  input logic            irq_en
);

  logic take_now;
  assign take_now = !reset_req && irq_en && (|irq_req);

  // R1
  always_comb begin
    if (!rst_n) begin
      p_reset_state_r1: assert (!fetch_vld && irq_ack == '0 && !irq_en);
    end
  end

  p_reset_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (fetch_vld && fetch_idx == '0 &&
                   fetch_addr == ($past(boot_fuse_n) ? {AW{1'b0}} : $past(boot_base))));

  p_reset_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (irq_ack == '0 && !irq_en));

  p_irq_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |=> (fetch_vld && fetch_idx != '0 &&
                  fetch_addr == (($past(vec_sel) ? $past(boot_base) : {AW{1'b0}}) + AW'(fetch_idx))));

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !irq_en) |=> !fetch_vld);

  p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |=> !irq_en);

  p_ack_matches_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> (irq_ack == (NSRC'(1) << (fetch_idx - IW'(1)))));

  p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  p_ack_with_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> fetch_vld);

  p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !take_now && ie_clr) |=> !irq_en);

  p_en_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !take_now && ie_set && !ie_clr) |=> irq_en);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !take_now) |=> (!fetch_vld && $stable(fetch_addr) && $stable(fetch_idx)));

endmodule

bind irqv_top irqv_chk #(.AW(AW), .NSRC(NSRC)) u_chk (.*);

// File: tb/irqv_top_tb.sv
`timescale 1ns/1ps
module irqv_top_tb;

  localparam int AW   = 16;
  localparam int NSRC = 18;
  localparam int IW   = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            boot_fuse_n;
  logic            vec_sel;
  logic [AW-1:0]   boot_base;
  logic            reset_req;
  logic            ie_set;
  logic            ie_clr;
  logic [NSRC-1:0] irq_req;
  logic            fetch_vld;
  logic [AW-1:0]   fetch_addr;
  logic [IW-1:0]   fetch_idx;
  logic [NSRC-1:0] irq_ack;
  logic            irq_en;

  always #2.5 clk = ~clk;

  irqv_top #(.AW(AW), .NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .boot_fuse_n(boot_fuse_n), .vec_sel(vec_sel),
    .boot_base(boot_base), .reset_req(reset_req), .ie_set(ie_set), .ie_clr(ie_clr),
    .irq_req(irq_req), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .fetch_idx(fetch_idx), .irq_ack(irq_ack), .irq_en(irq_en)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_en, m_vld;
  int          m_addr, m_idx;
  int          m_ack;
  string       m_tag;

  task automatic model_step();
    if (reset_req) begin
      m_vld = 1; m_idx = 0; m_ack = 0; m_en = 0;
      m_addr = boot_fuse_n ? 0 : int'(boot_base);
      m_tag = "R2";
    end else if (m_en && irq_req != 0) begin
      int k = 0;
      while (!irq_req[k]) k++;
      m_vld = 1; m_idx = k + 1; m_ack = 1 << k; m_en = 0;
      m_addr = ((vec_sel ? int'(boot_base) : 0) + k + 1) & 16'hFFFF;
      m_tag = "R4";
    end else begin
      m_vld = 0; m_ack = 0;
      if (ie_clr) m_en = 0;
      else if (ie_set) m_en = 1;
      m_tag = "R9";
    end
  endtask

  task automatic compare();
    chk(m_tag, "fetch_vld", fetch_vld, m_vld);
    chk(m_tag, "fetch_addr", fetch_addr, m_addr);
    chk(m_tag, "fetch_idx", fetch_idx, m_idx);
    chk("R7", "irq_ack", irq_ack, m_ack);
    chk("R8", "irq_en", irq_en, m_en);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  logic [31:0] rng = 32'h1234_5679;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    rst_n = 0; boot_fuse_n = 1; vec_sel = 0; boot_base = 16'h1E00;
    reset_req = 0; ie_set = 0; ie_clr = 0; irq_req = '0;
    m_en = 0; m_vld = 0; m_addr = 0; m_idx = 0; m_ack = 0; m_tag = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "fetch_vld in reset", fetch_vld, 0);
    chk("R1", "irq_en in reset", irq_en, 0);
    rst_n = 1;
    cyc();
    chk("R1", "irq_ack after reset", irq_ack, 0);
    chk("R1", "fetch_vld after reset", fetch_vld, 0);

    // Reset target, fuse unprogrammed then programmed
    reset_req = 1; cyc(); reset_req = 0;
    chk("R2", "reset addr fuse=1", fetch_addr, 0);
    chk("R2", "reset vld", fetch_vld, 1);
    boot_fuse_n = 0; reset_req = 1; cyc(); reset_req = 0; boot_fuse_n = 1;
    chk("R2", "reset addr fuse=0", fetch_addr, 16'h1E00);

    // Pending while disabled, then enable and take
    irq_req = (NSRC'(1) << 5) | (NSRC'(1) << 2);
    cyc();
    chk("R5", "no take while disabled", fetch_vld, 0);
    ie_set = 1; cyc(); ie_set = 0;
    chk("R8", "ie_set sets enable", irq_en, 1);
    cyc();
    chk("R6", "lowest offset wins", fetch_idx, 3);
    chk("R4", "vector addr vsel=0", fetch_addr, 3);
    chk("R7", "ack one-hot bit 2", irq_ack, 18'h4);
    chk("R5", "take clears enable", irq_en, 0);
    cyc();
    chk("R7", "ack lasts one cycle", irq_ack, 0);
    chk("R5", "no second take", fetch_vld, 0);
    irq_req = '0;

    // All four relocation combinations
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < 2; v++) begin
        boot_fuse_n = f[0]; vec_sel = v[0];
        ie_set = 1; cyc(); ie_set = 0;
        irq_req = NSRC'(1) << 17; cyc(); irq_req = '0;
        chk("R4", "last source addr", fetch_addr, (v != 0 ? 16'h1E00 : 0) + 18);
        chk("R6", "last source idx", fetch_idx, 18);
        reset_req = 1; cyc(); reset_req = 0;
        chk("R2", "reset addr independent of vsel", fetch_addr, f != 0 ? 0 : 16'h1E00);
      end
    end
    boot_fuse_n = 1; vec_sel = 0;

    // Reset collides with an enabled pending request
    ie_set = 1; cyc(); ie_set = 0;
    irq_req = '1; reset_req = 1; cyc(); reset_req = 0;
    chk("R3", "reset wins idx", fetch_idx, 0);
    chk("R3", "reset gives no ack", irq_ack, 0);
    chk("R3", "reset clears enable", irq_en, 0);
    cyc();
    chk("R3", "pending stays untaken", fetch_vld, 0);
    irq_req = '0;

    // Enable control collisions
    ie_set = 1; ie_clr = 1; cyc(); ie_clr = 0;
    chk("R8", "clear wins over set", irq_en, 0);
    cyc();
    chk("R8", "set alone", irq_en, 1);
    irq_req = NSRC'(1); cyc(); irq_req = '0; ie_set = 0;
    chk("R8", "take wins over set", irq_en, 0);
    chk("R6", "first source idx", fetch_idx, 1);
    cyc();
    chk("R9", "idle vld", fetch_vld, 0);
    chk("R9", "idle holds idx", fetch_idx, 1);

    // Pseudo-random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      rng = nxt(rng);
      reset_req   = (rng[7:0] == 8'h00);
      ie_set      = rng[8] | rng[9];
      ie_clr      = (rng[12:10] == 3'b000);
      boot_fuse_n = rng[13];
      vec_sel     = rng[14];
      boot_base   = {rng[31:24], 8'h00};
      rng = nxt(rng);
      irq_req     = rng[NSRC-1:0] & nxt(rng)[NSRC-1:0] & nxt(nxt(rng))[NSRC-1:0];
      cyc();
    end
    reset_req = 0; ie_set = 0; ie_clr = 0; irq_req = '0;
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule